// File: doc/BRIEF.md
# SPI Slave Transaction Error Monitor

This block sits beside the serial shifter of an SPI slave and checks every transaction at the moment the slave-select line returns to its inactive level. While select is active it counts sampling edges of the serial clock and compares the count with the configured word width. It also watches the transmit side for a word request that found the transmit queue empty. When select goes inactive, any mismatch or underrun is recorded in one of two sticky flags. Host logic clears each flag by writing one to it.

Select and the serial clock arrive asynchronously. A short flop chain brings both into the peripheral clock domain. The monitor then works only from edges of the synchronized signals. The transmit request and queue-empty inputs come from the shifter and are already in the peripheral clock domain.

Top module: `spi_txn_monitor`

## Requirements
- R1: After reset both `bit_err` and `tx_undr` are 0.
- R2: When select goes inactive after a number of sampling edges that is a nonzero whole multiple of the effective word width, `bit_err` is not set by that transaction.
- R3: When select goes inactive after a nonzero edge count that is not a whole multiple of the effective word width, `bit_err` becomes 1.
- R4: A transaction in which select was active but no sampling edge arrived sets `bit_err` when select goes inactive.
- R5: A cycle during the transaction with `tx_req`=1 and `tx_empty`=1 sets `tx_undr` when select goes inactive. Requests made while `tx_empty`=0 leave `tx_undr` at 0.
- R6: Each flag stays at 1 until its own clear input is pulsed high for one cycle, and it reads 0 from the next cycle on. If a flag's set event and its clear pulse fall in the same cycle, the set wins.
- R7: Neither flag changes from 0 to 1 except in the cycle that follows detection of select returning to inactive. Flags hold their value while select is active.
- R8: The captured underflow is discarded when select next becomes active. A transaction with no underflow does not set `tx_undr`, even if the previous transaction had one.
- R9: `cfg_width` below 8 is treated as 8, and above 32 is treated as 32.
- R10: Rising serial clock edges that occur while select is inactive are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_async | input | 1 | Slave select, active low, asynchronous |
| sck_async | input | 1 | Serial clock, asynchronous; the sampling edge is its rising edge |
| tx_req | input | 1 | Shifter asks for the next transmit word (one-cycle pulse) |
| tx_empty | input | 1 | Transmit queue holds no word |
| cfg_width | input | 6 | Word width in bits (8 to 32 effective) |
| clr_bit_err | input | 1 | Write-one-to-clear strobe for `bit_err` |
| clr_tx_undr | input | 1 | Write-one-to-clear strobe for `tx_undr` |
| bit_err | output | 1 | Sticky bit-count error flag |
| tx_undr | output | 1 | Sticky transmit underrun flag |

## Verification
The hardest case to reach from the ports is a clear pulse that falls in the same cycle as a flag's set event. That set event exists only for one cycle, a fixed number of synchronizer stages after select rises. The bench counts those stages from the edge at which it raises select and asserts the clear strobe in exactly that cycle. Random transactions mix edge counts that are exact multiples of the width with counts that are not. They also mix in-range and clamped widths, and they place transmit requests with the queue both empty and non-empty. Directed cases cover zero edges, idle clock edges and an underflow followed by a clean transaction.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    localparam int MIN_W = 8;
    localparam int MAX_W = 32;
    localparam int POS_W = $clog2(MAX_W);
    localparam int CFG_W = $clog2(MAX_W + 1);

    typedef logic [CFG_W-1:0] width_t;

    // position within the current word and whether any edge arrived
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             seen;
    } bitcnt_t;

    // edge events derived from synchronized select and serial clock
    typedef struct packed {
        logic open_ev;   // select became active
        logic close_ev;  // select became inactive
        logic sample_ev; // sampling edge while select active
    } sel_evt_t;

    typedef enum logic [1:0] {
        W_IN_RANGE = 2'd0,
        W_LOW      = 2'd1,
        W_HIGH     = 2'd2
    } wclass_t;

    function automatic wclass_t classify_width(width_t w);
        if (w < width_t'(MIN_W))      return W_LOW;
        else if (w > width_t'(MAX_W)) return W_HIGH;
        else                          return W_IN_RANGE;
    endfunction

    function automatic width_t clamp_width(width_t w);
        case (classify_width(w))
            W_LOW:   return width_t'(MIN_W);
            W_HIGH:  return width_t'(MAX_W);
            default: return w;
        endcase
    endfunction

    function automatic bitcnt_t bump(bitcnt_t c, width_t w);
        bitcnt_t n;
        n.seen = 1'b1;
        if (c.pos == POS_W'(w - width_t'(1))) n.pos = '0;
        else                                  n.pos = c.pos + POS_W'(1);
        return n;
    endfunction

    function automatic logic count_ok(bitcnt_t c);
        return c.seen && (c.pos == '0);
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int          STAGES = 2,
    parameter int          WIDTH  = 1,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= INIT;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= INIT;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mon_bitcnt.sv
module spi_mon_bitcnt
    import spi_mon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  logic    sample,
    input  width_t  width,
    output bitcnt_t cnt
);
    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (sample)    cnt <= bump(cnt, width);
    end
endmodule

// File: rtl/spi_mon_flags.sv
module spi_mon_flags
    import spi_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sel_evt_t ev,
    input  logic     sel_active,
    input  logic     words_ok,
    input  logic     tx_req,
    input  logic     tx_empty,
    input  logic     clr_bit_err,
    input  logic     clr_tx_undr,
    output logic     underflow_seen,
    output logic     bit_err,
    output logic     tx_undr
);
    logic set_bit, set_undr;

    always_ff @(posedge clk) begin
        if (rst || ev.open_ev)                         underflow_seen <= 1'b0;
        else if (sel_active && tx_req && tx_empty)     underflow_seen <= 1'b1;
    end

    always_comb begin
        set_bit  = ev.close_ev && !words_ok;
        set_undr = ev.close_ev && underflow_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_err <= 1'b0;
            tx_undr <= 1'b0;
        end else begin
            if (set_bit)          bit_err <= 1'b1;
            else if (clr_bit_err) bit_err <= 1'b0;
            if (set_undr)         tx_undr <= 1'b1;
            else if (clr_tx_undr) tx_undr <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_txn_monitor.sv
module spi_txn_monitor
    import spi_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_n_async,
    input  logic               sck_async,
    input  logic               tx_req,
    input  logic               tx_empty,
    input  logic [CFG_W-1:0]   cfg_width,
    input  logic               clr_bit_err,
    input  logic               clr_tx_undr,
    output logic               bit_err,
    output logic               tx_undr
);
    logic     sel_n_s, sck_s;
    logic     sel_n_q, sck_q;
    sel_evt_t ev;
    bitcnt_t  cnt;
    width_t   eff_w;
    logic     underflow_seen;
    logic     close_det;

    spi_mon_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .INIT(2'b10)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_n_async, sck_async}),
        .q   ({sel_n_s, sck_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_n_q <= 1'b1;
            sck_q   <= 1'b0;
        end else begin
            sel_n_q <= sel_n_s;
            sck_q   <= sck_s;
        end
    end

    always_comb begin
        ev.open_ev   = sel_n_q && !sel_n_s;
        ev.close_ev  = !sel_n_q && sel_n_s;
        ev.sample_ev = !sck_q && sck_s && !sel_n_s;
        eff_w        = clamp_width(cfg_width);
        close_det    = ev.close_ev;
    end

    spi_mon_bitcnt i_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (ev.open_ev),
        .sample  (ev.sample_ev),
        .width   (eff_w),
        .cnt     (cnt)
    );

    spi_mon_flags i_flags (
        .clk            (clk),
        .rst            (rst),
        .ev             (ev),
        .sel_active     (!sel_n_s),
        .words_ok       (count_ok(cnt)),
        .tx_req         (tx_req),
        .tx_empty       (tx_empty),
        .clr_bit_err    (clr_bit_err),
        .clr_tx_undr    (clr_tx_undr),
        .underflow_seen (underflow_seen),
        .bit_err        (bit_err),
        .tx_undr        (tx_undr)
    );
endmodule

// File: rtl/spi_txn_monitor_chk.sv
module spi_txn_monitor_chk (
    input logic clk,
    input logic rst,
    input logic close_det,
    input logic cnt_seen,
    input logic underflow_seen,
    input logic clr_bit_err,
    input logic clr_tx_undr,
    input logic bit_err,
    input logic tx_undr
);
    p_no_edges_err_r4: assert property (@(posedge clk) disable iff (rst)
        (close_det && !cnt_seen) |=> bit_err);

    p_undr_on_close_r5: assert property (@(posedge clk) disable iff (rst)
        (close_det && underflow_seen) |=> tx_undr);

    p_bit_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_err && !clr_bit_err) |=> bit_err);

    p_undr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_undr && !clr_tx_undr) |=> tx_undr);

    p_bit_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_bit_err && !close_det) |=> !bit_err);

    p_undr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_tx_undr && !close_det) |=> !tx_undr);

    p_bit_rise_only_at_close_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bit_err) |-> $past(close_det));

    p_undr_rise_only_at_close_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_undr) |-> $past(close_det));
endmodule

bind spi_txn_monitor spi_txn_monitor_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .close_det      (close_det),
    .cnt_seen       (cnt.seen),
    .underflow_seen (underflow_seen),
    .clr_bit_err    (clr_bit_err),
    .clr_tx_undr    (clr_tx_undr),
    .bit_err        (bit_err),
    .tx_undr        (tx_undr)
);

// File: tb/test_spi_txn_monitor.sv
`timescale 1ns/1ps
module test_spi_txn_monitor;
    logic       clk = 1'b0;
    logic       rst;
    logic       sel_n_async, sck_async, tx_req, tx_empty;
    logic [5:0] cfg_width;
    logic       clr_bit_err, clr_tx_undr;
    logic       bit_err, tx_undr;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_bit  = 1'b0;
    bit exp_undr = 1'b0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    spi_txn_monitor i_spi_txn_monitor (
        .clk(clk), .rst(rst), .sel_n_async(sel_n_async), .sck_async(sck_async),
        .tx_req(tx_req), .tx_empty(tx_empty), .cfg_width(cfg_width),
        .clr_bit_err(clr_bit_err), .clr_tx_undr(clr_tx_undr),
        .bit_err(bit_err), .tx_undr(tx_undr)
    );

    function automatic int eff_width(int w);
        if (w < 8)  return 8;
        if (w > 32) return 32;
        return w;
    endfunction

    function automatic bit count_bad(int n, int w);
        return !(n > 0 && (n % eff_width(w)) == 0);
    endfunction

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check(string req, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        check({req, " bit_err"}, bit_err, exp_bit);
        check({req, " tx_undr"}, tx_undr, exp_undr);
    endtask

    // mode: 0 no request, 1 request with empty queue, 2 request with data
    task automatic txn(string req, int n, int w, int mode);
        cfg_width   = 6'(w);
        sel_n_async = 1'b0;
        step(4);
        for (int i = 0; i < n; i++) begin
            sck_async = 1'b1; step(3);
            sck_async = 1'b0; step(3);
            if (i == 0 && mode != 0) begin
                tx_req = 1'b1; tx_empty = (mode == 1); step(1);
                tx_req = 1'b0; tx_empty = 1'b0;
            end
        end
        if (n == 0 && mode != 0) begin
            tx_req = 1'b1; tx_empty = (mode == 1); step(1);
            tx_req = 1'b0; tx_empty = 1'b0;
        end
        step(2);
        check_flags({req, " R7 hold while active"});
        sel_n_async = 1'b1;
        step(5);
        if (count_bad(n, w)) exp_bit = 1'b1;
        if (mode == 1)       exp_undr = 1'b1;
        check_flags(req);
    endtask

    task automatic clear_both();
        clr_bit_err = 1'b1; clr_tx_undr = 1'b1; step(1);
        clr_bit_err = 1'b0; clr_tx_undr = 1'b0;
        exp_bit = 1'b0; exp_undr = 1'b0;
        check_flags("R6 clear");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        rst = 1'b1; sel_n_async = 1'b1; sck_async = 1'b0; tx_req = 1'b0; tx_empty = 1'b0;
        cfg_width = 6'd8; clr_bit_err = 1'b0; clr_tx_undr = 1'b0;
        step(4);
        rst = 1'b0;
        step(2);
        check_flags("R1 reset");

        txn("R2 exact word", 8, 8, 0);
        txn("R2 two words", 32, 16, 0);
        txn("R3 short", 7, 8, 0);
        clear_both();
        txn("R4 no edges", 0, 8, 0);
        clear_both();
        txn("R5 underflow", 8, 8, 1);
        clear_both();
        txn("R5 request with data", 8, 8, 2);
        txn("R8 underflow", 16, 16, 1);
        clear_both();
        txn("R8 next clean", 16, 16, 0);
        txn("R9 low clamp", 8, 4, 0);
        txn("R9 high clamp", 32, 40, 0);
        txn("R9 low clamp mismatch", 4, 4, 0);
        clear_both();

        // R10: edges while idle are ignored
        for (int i = 0; i < 3; i++) begin
            sck_async = 1'b1; step(3); sck_async = 1'b0; step(3);
        end
        check_flags("R10 idle edges");
        txn("R10 exact after idle edges", 8, 8, 0);

        // R6: clear in same cycle as set -> set wins
        cfg_width = 6'd8; sel_n_async = 1'b0; step(4);
        for (int i = 0; i < 3; i++) begin
            sck_async = 1'b1; step(3); sck_async = 1'b0; step(3);
        end
        sel_n_async = 1'b1;
        step(2);
        clr_bit_err = 1'b1; step(1); clr_bit_err = 1'b0;
        exp_bit = 1'b1;
        check("R6 set beats clear", bit_err, 1'b1);
        step(3);
        check("R6 sticky", bit_err, 1'b1);
        clear_both();

        for (int t = 0; t < 40; t++) begin
            int w, n, mode;
            w = ($urandom % 8 == 0) ? int'($urandom % 64) : 8 + int'($urandom % 25);
            if ($urandom % 2) n = eff_width(w) * (1 + int'($urandom % 2));
            else              n = int'($urandom % 70);
            mode = int'($urandom % 3);
            txn("R2/R3/R5 random", n, w, mode);
            if ($urandom % 3 == 0) clear_both();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule